// File: doc/BRIEF.md
# Binary32 Adder/Accumulator with Mode-Selected Operands

This block adds two single-precision (binary32) operands and presents a binary32 result together with invalid, overflow and underflow flags. A 7-bit operation word selects the two operands. The first operand, called P0, can be zero, an incoming product, the C word, or the block's own registered result. The second operand, called P1, can be zero, the product, C, a cascade word from a neighbouring slice, or the registered result. Each operand can have its sign flipped on its own before the addition, so the one datapath performs add, subtract, negate and accumulate.

The operation word and the C word each pass through a pipeline whose depth is set by a parameter (0 to 3 stages). Each pipeline has its own clock enable and synchronous clear, so a control word can be lined up with the data it governs. The result register is optional. The accumulation feedback always comes from a registered copy of the result, so a feedback loop is never combinational. A static parameter sets whether the 32-bit cascade output carries the sum or the incoming product.

Top module: `fpadd_opsel`

## Requirements
- R1: Operation bits [1:0] select P0: 00 = +0, 01 = product, 10 = C after its pipeline, 11 = registered result.
- R2: Operation bits [4:2] select P1: 000 = +0, 001 = product, 010 = C, 011 = cascade input, 100 = registered result. Codes 101, 110 and 111 read as +0.
- R3: Bit 5 inverts the sign bit of P0 and bit 6 inverts the sign bit of P1 before the addition. Only bit 31 changes, and NaN operands are flipped too.
- R4: The sum of finite operands is rounded to nearest, with ties to even. An exact cancellation gives +0, and two negative zeros give -0.
- R5: A NaN operand, or the sum of opposite infinities, gives 0x7FC00000 with the invalid flag set. A single infinity passes through with no flag.
- R6: A finite sum whose magnitude rounds above the largest finite value gives a signed infinity with the overflow flag set.
- R7: A non-zero result below the smallest normal magnitude is flushed to a zero of the result's sign and raises the underflow flag. A subnormal input operand is treated as a zero.
- R8: The operation word reaches the adder after MODE_STAGES register stages (default 1). These stages advance only when mode_ce is high, and mode_clr loads all-zero.
- R9: The C word reaches the operand mux after C_STAGES register stages (default 1). These stages advance on c_ce, and c_clr loads zero.
- R10: With OUT_REG=1 the sum and flags change one clock edge after the adder inputs. They hold while out_ce is low, and out_clr zeroes them with priority over out_ce.
- R11: The accumulation source (P0 code 11, P1 code 100) is the result register, which updates under out_ce and out_clr, so repeated edges add the selected operand again and again.
- R12: cas_o carries the sum when CAS_SUM=1 (default) and product_i when CAS_SUM=0.
- R13: While rst_n is low, all pipeline stages and the result register are zero, so the sum, the flags and the cascade output (with CAS_SUM=1) read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| product_i | input | 32 | Product from the multiplier, binary32 |
| c_i | input | 32 | C operand, binary32 |
| cas_i | input | 32 | Cascade input from the previous slice |
| mode_i | input | 7 | Operation word (operand selects and sign flips) |
| mode_ce | input | 1 | Enable for the operation-word pipeline |
| mode_clr | input | 1 | Synchronous clear for the operation-word pipeline |
| c_ce | input | 1 | Enable for the C pipeline |
| c_clr | input | 1 | Synchronous clear for the C pipeline |
| out_ce | input | 1 | Enable for the result register |
| out_clr | input | 1 | Synchronous clear for the result register |
| sum_o | output | 32 | Binary32 sum |
| invalid_o | output | 1 | Sum is NaN |
| overflow_o | output | 1 | Sum overflowed to infinity |
| underflow_o | output | 1 | Tiny non-zero sum flushed to zero |
| cas_o | output | 32 | Cascade output: sum or product |

## Verification
Accumulation and result-register clearing can fall in the same cycle: the feedback path is still selected when out_clr is raised in the middle of a running sum. The bench builds a running total of +1.0 steps, asserts out_clr for exactly one edge while the accumulate code stays selected, and expects the result to be zero after that edge and to equal the bare product one edge later. A second case raises a change of operation word and a change of C in the same cycle as a held result register, and checks that the result stays frozen until the enable returns.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

  localparam int unsigned FW = 32;
  localparam int unsigned MW = 7;
  localparam logic [FW-1:0] QNAN = 32'h7FC0_0000;

  typedef enum logic [1:0] {
    P0_ZERO = 2'b00,
    P0_PROD = 2'b01,
    P0_CIN  = 2'b10,
    P0_ACC  = 2'b11
  } p0_sel_e;

  typedef enum logic [2:0] {
    P1_ZERO = 3'b000,
    P1_PROD = 3'b001,
    P1_CIN  = 3'b010,
    P1_CAS  = 3'b011,
    P1_ACC  = 3'b100
  } p1_sel_e;

  typedef struct packed {
    logic [FW-1:0] val;
    logic          inv;
    logic          ovf;
    logic          unf;
  } fpres_t;

  // position of the leading one, counted from bit 26
  function automatic logic [4:0] lead_zeros27(input logic [26:0] v);
    logic [4:0] n;
    n = 5'd27;
    for (int i = 0; i < 27; i++) begin
      if (v[i]) n = 5'(26 - i);
    end
    return n;
  endfunction

endpackage

// File: rtl/fpadd_pipe.sv
module fpadd_pipe #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (DEPTH == 0) begin : g_bypass
      assign q = d;
    end else begin : g_stages
      logic [W-1:0] stg_q [DEPTH];
      logic [W-1:0] stg_d [DEPTH];

      for (genvar i = 0; i < DEPTH; i++) begin : g_stg
        if (i == 0) begin : g_first
          always_comb begin
            if (clr)     stg_d[i] = '0;
            else if (ce) stg_d[i] = d;
            else         stg_d[i] = stg_q[i];
          end
        end else begin : g_next
          always_comb begin
            if (clr)     stg_d[i] = '0;
            else if (ce) stg_d[i] = stg_q[i-1];
            else         stg_d[i] = stg_q[i];
          end
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[i] <= '0;
          else        stg_q[i] <= stg_d[i];
        end
      end

      assign q = stg_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/fpadd_core.sv
module fpadd_core
  import fpadd_pkg::*;
(
  input  logic [FW-1:0] op_a,
  input  logic [FW-1:0] op_b,
  output fpres_t        res
);

  logic        a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;
  logic        swap;
  logic [31:0] big, sml;
  logic [7:0]  ediff;
  logic [5:0]  shamt;
  logic [49:0] sm_full;
  logic [26:0] big27, sml27, diff27, mnorm;
  logic [27:0] sum28;
  logic [4:0]  lz;
  logic        rup;
  logic [24:0] mrnd;
  logic [9:0]  e_pre, e_fin;
  logic [22:0] frac;

  always_comb begin
    a_nan  = (&op_a[30:23]) &&  (|op_a[22:0]);
    b_nan  = (&op_b[30:23]) &&  (|op_b[22:0]);
    a_inf  = (&op_a[30:23]) && !(|op_a[22:0]);
    b_inf  = (&op_b[30:23]) && !(|op_b[22:0]);
    a_zero = (op_a[30:23] == 8'd0);
    b_zero = (op_b[30:23] == 8'd0);

    // larger magnitude goes first
    swap  = (op_b[30:0] > op_a[30:0]);
    big   = swap ? op_b : op_a;
    sml   = swap ? op_a : op_b;
    ediff = big[30:23] - sml[30:23];
    shamt = (ediff > 8'd50) ? 6'd50 : ediff[5:0];

    sm_full = {1'b1, sml[22:0], 26'd0} >> shamt;
    sml27   = {sm_full[49:24], |sm_full[23:0]};
    big27   = {1'b1, big[22:0], 3'b000};
    sum28   = {1'b0, big27} + {1'b0, sml27};
    diff27  = big27 - sml27;
    lz      = lead_zeros27(diff27);

    if (big[31] == sml[31]) begin
      if (sum28[27]) begin
        mnorm = {sum28[27:2], |sum28[1:0]};
        e_pre = {2'b00, big[30:23]} + 10'd1;
      end else begin
        mnorm = sum28[26:0];
        e_pre = {2'b00, big[30:23]};
      end
    end else begin
      mnorm = diff27 << lz;
      e_pre = {2'b00, big[30:23]} - {5'd0, lz};
    end

    // nearest, ties to even on guard/round/sticky
    rup   = mnorm[2] & (mnorm[1] | mnorm[0] | mnorm[3]);
    mrnd  = {1'b0, mnorm[26:3]} + {24'd0, rup};
    e_fin = mrnd[24] ? e_pre + 10'd1 : e_pre;
    frac  = mrnd[24] ? mrnd[23:1] : mrnd[22:0];

    res = '0;
    if (a_nan || b_nan || (a_inf && b_inf && (op_a[31] != op_b[31]))) begin
      res.val = QNAN;
      res.inv = 1'b1;
    end else if (a_inf) begin
      res.val = op_a;
    end else if (b_inf) begin
      res.val = op_b;
    end else if (a_zero && b_zero) begin
      res.val = {op_a[31] & op_b[31], 31'd0};
    end else if (a_zero) begin
      res.val = op_b;
    end else if (b_zero) begin
      res.val = op_a;
    end else if ((big[31] != sml[31]) && (diff27 == 27'd0)) begin
      res.val = 32'd0;
    end else if ($signed(e_fin) <= 0) begin
      res.val = {big[31], 31'd0};
      res.unf = 1'b1;
    end else if ($signed(e_fin) >= 255) begin
      res.val = {big[31], 8'hFF, 23'd0};
      res.ovf = 1'b1;
    end else begin
      res.val = {big[31], e_fin[7:0], frac};
    end
  end

endmodule

// File: rtl/fpadd_opsel.sv
module fpadd_opsel
  import fpadd_pkg::*;
#(
  parameter int unsigned C_STAGES    = 1,
  parameter int unsigned MODE_STAGES = 1,
  parameter bit          OUT_REG     = 1'b1,
  parameter bit          CAS_SUM     = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] product_i,
  input  logic [FW-1:0] c_i,
  input  logic [FW-1:0] cas_i,
  input  logic [MW-1:0] mode_i,
  input  logic          mode_ce,
  input  logic          mode_clr,
  input  logic          c_ce,
  input  logic          c_clr,
  input  logic          out_ce,
  input  logic          out_clr,
  output logic [FW-1:0] sum_o,
  output logic          invalid_o,
  output logic          overflow_o,
  output logic          underflow_o,
  output logic [FW-1:0] cas_o
);

  logic [MW-1:0] eff_mode;
  logic [FW-1:0] c_q;
  logic [FW-1:0] op0_raw, op1_raw, op0, op1;
  fpres_t        core_res, res_d, res_q, res_out;
  p0_sel_e       p0_sel;
  p1_sel_e       p1_sel;

  fpadd_pipe #(.W(MW), .DEPTH(MODE_STAGES)) u_mode_pipe (
    .clk(clk), .rst_n(rst_n), .ce(mode_ce), .clr(mode_clr),
    .d(mode_i), .q(eff_mode)
  );

  fpadd_pipe #(.W(FW), .DEPTH(C_STAGES)) u_c_pipe (
    .clk(clk), .rst_n(rst_n), .ce(c_ce), .clr(c_clr),
    .d(c_i), .q(c_q)
  );

  assign p0_sel = p0_sel_e'(eff_mode[1:0]);
  assign p1_sel = p1_sel_e'(eff_mode[4:2]);

  always_comb begin
    unique case (p0_sel)
      P0_PROD: op0_raw = product_i;
      P0_CIN:  op0_raw = c_q;
      P0_ACC:  op0_raw = res_q.val;
      default: op0_raw = '0;
    endcase
    case (p1_sel)
      P1_PROD: op1_raw = product_i;
      P1_CIN:  op1_raw = c_q;
      P1_CAS:  op1_raw = cas_i;
      P1_ACC:  op1_raw = res_q.val;
      default: op1_raw = '0;
    endcase
    op0 = {op0_raw[31] ^ eff_mode[5], op0_raw[30:0]};
    op1 = {op1_raw[31] ^ eff_mode[6], op1_raw[30:0]};
  end

  fpadd_core u_core (.op_a(op0), .op_b(op1), .res(core_res));

  // result register: feeds accumulation whatever OUT_REG says
  always_comb begin
    if (out_clr)     res_d = '0;
    else if (out_ce) res_d = core_res;
    else             res_d = res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  generate
    if (OUT_REG) begin : g_oreg
      assign res_out = res_q;
    end else begin : g_ocomb
      assign res_out = core_res;
    end
    if (CAS_SUM) begin : g_cas_sum
      assign cas_o = res_out.val;
    end else begin : g_cas_prod
      assign cas_o = product_i;
    end
  endgenerate

  assign sum_o       = res_out.val;
  assign invalid_o   = res_out.inv;
  assign overflow_o  = res_out.ovf;
  assign underflow_o = res_out.unf;

endmodule

// File: rtl/fpadd_opsel_chk.sv
module fpadd_opsel_chk #(
  parameter bit          OUT_REG     = 1'b1,
  parameter int unsigned MODE_STAGES = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        out_ce,
  input logic        out_clr,
  input logic        mode_clr,
  input logic [31:0] sum_o,
  input logic        invalid_o,
  input logic        overflow_o,
  input logic        underflow_o,
  input logic [6:0]  eff_mode
);

  p_nan_canon_r5: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> (sum_o == 32'h7FC0_0000));

  p_ovf_inf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> (sum_o[30:0] == 31'h7F80_0000));

  p_unf_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> (sum_o[30:0] == 31'd0));

  p_flag_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({invalid_o, overflow_o, underflow_o}));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && !out_ce && !out_clr) |=> $stable(sum_o));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && out_clr) |=> (sum_o == 32'd0 && !invalid_o && !overflow_o && !underflow_o));

  p_mode_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((MODE_STAGES > 0) && mode_clr) |=> (eff_mode == 7'd0));

endmodule

bind fpadd_opsel fpadd_opsel_chk #(.OUT_REG(OUT_REG), .MODE_STAGES(MODE_STAGES)) u_chk (.*);

// File: tb/tb_fpadd_opsel.sv
module tb_fpadd_opsel;

  localparam int NV = 20;
  // {mode, product, c, cascade, expected sum, {inv,ovf,unf}}
  localparam logic [137:0] VEC [NV] = '{
    {7'h09, 32'h3F800000, 32'h40000000, 32'h00000000, 32'h40400000, 3'b000},
    {7'h0E, 32'h00000000, 32'h3FC00000, 32'h3F000000, 32'h40000000, 3'b000},
    {7'h04, 32'hBF800000, 32'h00000000, 32'h00000000, 32'hBF800000, 3'b000},
    {7'h15, 32'h40400000, 32'h3F800000, 32'h00000000, 32'h40400000, 3'b000},
    {7'h1D, 32'h40400000, 32'h3F800000, 32'h00000000, 32'h40400000, 3'b000},
    {7'h49, 32'h40400000, 32'h3F800000, 32'h00000000, 32'h40000000, 3'b000},
    {7'h29, 32'h3F800000, 32'h40800000, 32'h00000000, 32'h40400000, 3'b000},
    {7'h09, 32'h3F800000, 32'h33800000, 32'h00000000, 32'h3F800000, 3'b000},
    {7'h09, 32'h3F800001, 32'h33800000, 32'h00000000, 32'h3F800002, 3'b000},
    {7'h49, 32'h3FC00000, 32'h3FC00000, 32'h00000000, 32'h00000000, 3'b000},
    {7'h09, 32'h7F800001, 32'h3F800000, 32'h00000000, 32'h7FC00000, 3'b100},
    {7'h29, 32'h7F800001, 32'h3F800000, 32'h00000000, 32'h7FC00000, 3'b100},
    {7'h09, 32'h7F800000, 32'hFF800000, 32'h00000000, 32'h7FC00000, 3'b100},
    {7'h09, 32'h7F800000, 32'h3F800000, 32'h00000000, 32'h7F800000, 3'b000},
    {7'h09, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h00000000, 32'h7F800000, 3'b010},
    {7'h49, 32'h00C00000, 32'h00800000, 32'h00000000, 32'h00000000, 3'b001},
    {7'h29, 32'h00C00000, 32'h00800000, 32'h00000000, 32'h80000000, 3'b001},
    {7'h09, 32'h00000001, 32'h3F800000, 32'h00000000, 32'h3F800000, 3'b000},
    {7'h09, 32'h80000000, 32'h80000000, 32'h00000000, 32'h80000000, 3'b000},
    {7'h4D, 32'h40800000, 32'h00000000, 32'h3F800000, 32'h40400000, 3'b000}
  };

  logic        clk, rst_n;
  logic [31:0] product_i, c_i, cas_i;
  logic [6:0]  mode_i;
  logic        mode_ce, mode_clr, c_ce, c_clr, out_ce, out_clr;
  logic [31:0] sum_o, cas_o, sum_p, cas_p;
  logic        invalid_o, overflow_o, underflow_o, inv_p, ovf_p, unf_p;
  int          checks, errors;
  logic        done;

  fpadd_opsel dut (
    .clk(clk), .rst_n(rst_n), .product_i(product_i), .c_i(c_i), .cas_i(cas_i),
    .mode_i(mode_i), .mode_ce(mode_ce), .mode_clr(mode_clr), .c_ce(c_ce), .c_clr(c_clr),
    .out_ce(out_ce), .out_clr(out_clr), .sum_o(sum_o), .invalid_o(invalid_o),
    .overflow_o(overflow_o), .underflow_o(underflow_o), .cas_o(cas_o)
  );

  fpadd_opsel #(.C_STAGES(0), .MODE_STAGES(0), .OUT_REG(1'b0), .CAS_SUM(1'b0)) dut_p (
    .clk(clk), .rst_n(rst_n), .product_i(product_i), .c_i(c_i), .cas_i(cas_i),
    .mode_i(mode_i), .mode_ce(mode_ce), .mode_clr(mode_clr), .c_ce(c_ce), .c_clr(c_clr),
    .out_ce(out_ce), .out_clr(out_clr), .sum_o(sum_p), .invalid_o(inv_p),
    .overflow_o(ovf_p), .underflow_o(unf_p), .cas_o(cas_p)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h/%b expected=%h/%b", tag, act[34:3], act[2:0], exp[34:3], exp[2:0]);
    end
  endtask

  function automatic string vtag(input int i);
    case (i)
      0, 2:             return "R1 vector";
      1, 3, 4, 19:      return "R2 vector";
      5, 6, 11:         return "R3 vector";
      7, 8, 9, 18:      return "R4 vector";
      10, 12, 13:       return "R5 vector";
      14:               return "R6 vector";
      default:          return "R7 vector";
    endcase
  endfunction

  function automatic logic [34:0] got();
    return {sum_o, invalid_o, overflow_o, underflow_o};
  endfunction

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    done = 1'b0;
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0;
    product_i = '0; c_i = '0; cas_i = '0; mode_i = '0;
    mode_ce = 1'b1; mode_clr = 1'b0; c_ce = 1'b1; c_clr = 1'b0;
    out_ce = 1'b1; out_clr = 1'b0;
    mode_i = 7'h09; product_i = 32'h3F800000; c_i = 32'h40000000;
    edges(3);
    // R13: reset state
    chk("R13 reset sum/flags", got(), 35'd0);
    chk("R13 reset cascade", {cas_o, 3'b000}, 35'd0);
    rst_n = 1'b1;

    // vector table
    for (int i = 0; i < NV; i++) begin
      mode_i = VEC[i][137:131]; product_i = VEC[i][130:99];
      c_i = VEC[i][98:67]; cas_i = VEC[i][66:35];
      edges(3);
      chk($sformatf("%s %0d", vtag(i), i), got(), VEC[i][34:0]);
      chk($sformatf("%s %0d unregistered", vtag(i), i), {sum_p, inv_p, ovf_p, unf_p}, VEC[i][34:0]);
    end

    // R12: cascade selection
    chk("R12 cascade carries sum", {cas_o, 3'b000}, {sum_o, 3'b000});
    chk("R12 cascade carries product", {cas_p, 3'b000}, {product_i, 3'b000});

    // R8: mode pipeline latency, enable and clear
    mode_i = 7'h09; product_i = 32'h3F800000; c_i = 32'h40000000; cas_i = '0;
    edges(3);
    mode_i = 7'h04;
    edges(1);
    chk("R8 mode one stage: old result still out", got(), {32'h40400000, 3'b000});
    edges(1);
    chk("R8 mode reaches output after two edges", got(), {32'h3F800000, 3'b000});
    mode_ce = 1'b0; mode_i = 7'h09;
    edges(3);
    chk("R8 mode held while mode_ce low", got(), {32'h3F800000, 3'b000});
    mode_clr = 1'b1;
    edges(1);
    mode_clr = 1'b0; mode_ce = 1'b1;
    edges(1);
    chk("R8 mode_clr selects zero operands", got(), {32'h00000000, 3'b000});
    edges(2);
    chk("R8 mode restored", got(), {32'h40400000, 3'b000});

    // R9: C pipeline latency, enable and clear
    c_i = 32'h40800000;
    edges(1);
    chk("R9 C one stage: old result", got(), {32'h40400000, 3'b000});
    edges(1);
    chk("R9 new C at output", got(), {32'h40A00000, 3'b000});
    c_ce = 1'b0; c_i = 32'h3F800000;
    edges(3);
    chk("R9 C held while c_ce low", got(), {32'h40A00000, 3'b000});
    c_clr = 1'b1;
    edges(1);
    c_clr = 1'b0; c_ce = 1'b1; c_i = 32'h40000000;
    edges(1);
    chk("R9 c_clr gives C of zero", got(), {32'h3F800000, 3'b000});
    edges(2);

    // R10: result hold and clear; mode and C change while held
    out_ce = 1'b0; product_i = 32'h40000000; mode_i = 7'h49; c_i = 32'h3F000000;
    edges(3);
    chk("R10 result held while out_ce low", got(), {32'h40400000, 3'b000});
    out_ce = 1'b1;
    edges(1);
    chk("R10 result updates one edge after enable", got(), {32'h3FC00000, 3'b000});
    out_clr = 1'b1;
    edges(1);
    chk("R10 out_clr zeroes result", got(), 35'd0);

    // R11: accumulation through P0, clear in mid-run
    mode_i = 7'h07; product_i = 32'h3F800000;
    edges(2);
    out_clr = 1'b0;
    edges(1);
    chk("R11 accumulate step 1", got(), {32'h3F800000, 3'b000});
    edges(1);
    chk("R11 accumulate step 2", got(), {32'h40000000, 3'b000});
    edges(1);
    chk("R11 accumulate step 3", got(), {32'h40400000, 3'b000});
    out_clr = 1'b1;
    edges(1);
    chk("R11 clear wins during accumulation", got(), 35'd0);
    out_clr = 1'b0;
    edges(1);
    chk("R11 restart from zero after clear", got(), {32'h3F800000, 3'b000});

    // R11: accumulation through P1 code 100
    mode_i = 7'h11; product_i = 32'h40000000; out_clr = 1'b1;
    edges(2);
    out_clr = 1'b0;
    edges(1);
    chk("R11 P1 accumulate step 1", got(), {32'h40000000, 3'b000});
    edges(1);
    chk("R11 P1 accumulate step 2", got(), {32'h40800000, 3'b000});

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule